// File: doc/BRIEF.md
# Two-Port Hotplug Interrupt Aggregator

This block collects interrupt causes for a two-port serial storage host and turns them into a single host interrupt. Each port has four causes: a device request, a power-management event, a device attach and a device detach. A one-cycle pulse on any cause input sets a sticky bit in a shared status byte. Software reads that byte, clears bits by writing ones, and chooses which causes may interrupt through an enable byte of the same layout. A configuration bit then sends the combined interrupt either to a normal interrupt line or to a system-management interrupt line.

Port p owns the four status and enable bits at positions 4p+3 down to 4p. Inside a group, bit 0 is device request, bit 1 is power management, bit 2 is attach and bit 3 is detach. Software masks a port by writing back the enable byte with that port's four bits cleared. It unmasks a port by first clearing that port's four status bits and then setting only the device, attach and detach enables.

Delivery runs through a three-state machine, clocked once per cycle. DLV_QUIET drives both lines low. DLV_NORMAL drives the normal line and DLV_SMI drives the system-management line. From any state the next state is DLV_QUIET when no enabled cause is pending. With a pending enabled cause it is DLV_NORMAL when the routing bit is 0 and DLV_SMI when it is 1. So the transitions are QUIET→NORMAL, QUIET→SMI, NORMAL→QUIET, NORMAL→SMI, SMI→QUIET and SMI→NORMAL, plus the self-loops.

Top module: `irq_hotplug_agg`

## Requirements
- R1: After reset, and after any later reset, status, enable and routing are zero, `irq_o`, `smi_o` and `rd_data_o` are low, and reads of all three registers return zero.
- R2: A pulse on a cause input of port p sets status bit 4p+c at the next clock edge, where c is 0 for device request, 1 for power management, 2 for attach and 3 for detach. The bit then stays set until it is cleared.
- R3: A write to the status register (offset 0x10) clears every status bit written as 1. Bits written as 0 keep their value.
- R4: When a cause pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register (offset 0x11) stores the whole written byte and reads it back unchanged.
- R6: Bit 0 of the routing register (offset 0x12) is stored. Its other bits read as zero. With routing 1, a pending enabled cause drives `smi_o`.
- R7: One cycle after any bit of (status AND enable) is set, the selected output is high. Only one output is ever high at a time, and both are low one cycle after no enabled bit is set.
- R8: A read of any other offset returns zero, and a write to any other offset changes no register.
- R9: `rd_data_o` takes the addressed register's value at the clock edge where `rd_en_i` is high, and holds that value while `rd_en_i` is low.
- R10: After a port is unmasked by clearing its status nibble and then setting enable bits 0, 2 and 3 of its group, its power-management cause does not raise an interrupt and its device-request cause does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_dev_i | input | NUM_PORTS | Device-request pulse, one bit per port |
| evt_pm_i | input | NUM_PORTS | Power-management pulse, one bit per port |
| evt_add_i | input | NUM_PORTS | Device-attach pulse, one bit per port |
| evt_rem_i | input | NUM_PORTS | Device-detach pulse, one bit per port |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register offset |
| wr_data_i | input | 4*NUM_PORTS | Write data |
| rd_data_o | output | 4*NUM_PORTS | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| smi_o | output | 1 | System-management interrupt line |

## Verification
The bench builds the block with its default parameters: two ports, an eight-bit offset and the offsets 0x10, 0x11 and 0x12. With these values a single byte holds both port groups. So each test can reach cross-port isolation, nibble-wide masking and the unmask sequence on one port while the other port has a cause pending. The small offset space also lets the bench pick an unmapped offset right next to the mapped ones.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Cause positions inside one port group
    localparam int CAUSE_DEV  = 0;
    localparam int CAUSE_PM   = 1;
    localparam int CAUSE_ADD  = 2;
    localparam int CAUSE_REM  = 3;
    localparam int GRP_W      = 4;

    typedef enum logic [1:0] {
        DLV_QUIET  = 2'd0,
        DLV_NORMAL = 2'd1,
        DLV_SMI    = 2'd2
    } dlv_state_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_agg_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int VEC_W = NUM_PORTS * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] set_vec_i,
    input  logic [VEC_W-1:0] clr_vec_i,
    output logic [VEC_W-1:0] stat_o
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar c = 0; c < GRP_W; c++) begin : g_cause
            localparam int B = p * GRP_W + c;
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_vec_i[B]) begin
                    bit_q <= 1'b1;          // set takes precedence
                end else if (clr_vec_i[B]) begin
                    bit_q <= 1'b0;
                end
            end
            assign stat_o[B] = bit_q;
        end
    end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_agg_pkg::*;
#(
    parameter int              NUM_PORTS = 2,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] EN_OFS   = 8'h11,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h12,
    localparam int VEC_W = NUM_PORTS * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [VEC_W-1:0]  wr_data_i,
    input  logic [VEC_W-1:0]  stat_i,
    output logic [VEC_W-1:0]  clr_vec_o,
    output logic [VEC_W-1:0]  en_o,
    output logic              smi_sel_o,
    output logic [VEC_W-1:0]  rd_data_o
);

    logic             hit_stat, hit_en, hit_cfg;
    logic [VEC_W-1:0] en_q;
    logic             smi_sel_q;
    logic [VEC_W-1:0] rd_q;
    logic [VEC_W-1:0] rd_mux;

    always_comb begin
        hit_stat = (addr_i == STAT_OFS);
        hit_en   = (addr_i == EN_OFS);
        hit_cfg  = (addr_i == CFG_OFS);
    end

    // write-one-to-clear request toward the status bank
    assign clr_vec_o = (wr_en_i && hit_stat) ? wr_data_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            smi_sel_q <= 1'b0;
        end else if (wr_en_i) begin
            if (hit_en)  en_q      <= wr_data_i;
            if (hit_cfg) smi_sel_q <= wr_data_i[0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_stat)     rd_mux = stat_i;
        else if (hit_en)  rd_mux = en_q;
        else if (hit_cfg) rd_mux = {{(VEC_W-1){1'b0}}, smi_sel_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_mux;
    end

    assign en_o      = en_q;
    assign smi_sel_o = smi_sel_q;
    assign rd_data_o = rd_q;

endmodule

// File: rtl/irq_route_fsm.sv
module irq_route_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic smi_sel_i,
    output logic irq_o,
    output logic smi_o
);

    dlv_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DLV_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLV_QUIET: begin
                if (pending_i) state_d = smi_sel_i ? DLV_SMI : DLV_NORMAL;
            end
            DLV_NORMAL: begin
                if (!pending_i)     state_d = DLV_QUIET;
                else if (smi_sel_i) state_d = DLV_SMI;
            end
            DLV_SMI: begin
                if (!pending_i)      state_d = DLV_QUIET;
                else if (!smi_sel_i) state_d = DLV_NORMAL;
            end
            default: state_d = DLV_QUIET;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        smi_o = 1'b0;
        unique case (state_q)
            DLV_QUIET:  ;
            DLV_NORMAL: irq_o = 1'b1;
            DLV_SMI:    smi_o = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/irq_hotplug_agg.sv
module irq_hotplug_agg
    import irq_agg_pkg::*;
#(
    parameter int                NUM_PORTS = 2,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h10,
    parameter logic [ADDR_W-1:0] EN_OFS    = 8'h11,
    parameter logic [ADDR_W-1:0] CFG_OFS   = 8'h12,
    localparam int VEC_W = NUM_PORTS * GRP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] evt_dev_i,
    input  logic [NUM_PORTS-1:0] evt_pm_i,
    input  logic [NUM_PORTS-1:0] evt_add_i,
    input  logic [NUM_PORTS-1:0] evt_rem_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [VEC_W-1:0]     wr_data_i,
    output logic [VEC_W-1:0]     rd_data_o,
    output logic                 irq_o,
    output logic                 smi_o
);

    logic [VEC_W-1:0] evt_vec;
    logic [VEC_W-1:0] clr_vec;
    logic [VEC_W-1:0] stat_vec;
    logic [VEC_W-1:0] en_vec;
    logic             smi_sel;
    logic             pending;

    // pack per-port causes into their groups
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pack
        assign evt_vec[p*GRP_W + CAUSE_DEV] = evt_dev_i[p];
        assign evt_vec[p*GRP_W + CAUSE_PM]  = evt_pm_i[p];
        assign evt_vec[p*GRP_W + CAUSE_ADD] = evt_add_i[p];
        assign evt_vec[p*GRP_W + CAUSE_REM] = evt_rem_i[p];
    end

    irq_status_bank #(.NUM_PORTS(NUM_PORTS)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec_i (evt_vec),
        .clr_vec_i (clr_vec),
        .stat_o    (stat_vec)
    );

    irq_ctrl_regs #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W),
        .STAT_OFS  (STAT_OFS),
        .EN_OFS    (EN_OFS),
        .CFG_OFS   (CFG_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .stat_i    (stat_vec),
        .clr_vec_o (clr_vec),
        .en_o      (en_vec),
        .smi_sel_o (smi_sel),
        .rd_data_o (rd_data_o)
    );

    assign pending = |(stat_vec & en_vec);

    irq_route_fsm u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .smi_sel_i (smi_sel),
        .irq_o     (irq_o),
        .smi_o     (smi_o)
    );

endmodule

// File: rtl/irq_hotplug_agg_chk.sv
module irq_hotplug_agg_chk #(
    parameter int                VEC_W    = 8,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] EN_OFS   = 8'h11,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [VEC_W-1:0]  evt_vec,
    input logic [VEC_W-1:0]  stat_vec,
    input logic [VEC_W-1:0]  en_vec,
    input logic              smi_sel,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [VEC_W-1:0]  wr_data_i,
    input logic [VEC_W-1:0]  rd_data_o,
    input logic              irq_o,
    input logic              smi_o
);

    logic unmapped;
    assign unmapped = (addr_i != STAT_OFS) && (addr_i != EN_OFS) && (addr_i != CFG_OFS);

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && smi_o)); // R7

    AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((stat_vec & $past(evt_vec)) == $past(evt_vec))); // R2

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == STAT_OFS) |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec))); // R2

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == STAT_OFS && evt_vec == '0) |=> ((stat_vec & $past(wr_data_i)) == '0)); // R3

    AST_ROUTE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(stat_vec & en_vec)) && !smi_sel) |=> irq_o); // R7

    AST_ROUTE_SMI: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(stat_vec & en_vec)) && smi_sel) |=> smi_o); // R6

    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_vec & en_vec)) |=> (!irq_o && !smi_o)); // R7

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && unmapped) |=> (rd_data_o == '0)); // R8

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && unmapped) |=> ($stable(en_vec) && $stable(smi_sel))); // R8

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o)); // R9

endmodule

bind irq_hotplug_agg irq_hotplug_agg_chk #(
    .VEC_W    (VEC_W),
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .EN_OFS   (EN_OFS),
    .CFG_OFS  (CFG_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_vec   (evt_vec),
    .stat_vec  (stat_vec),
    .en_vec    (en_vec),
    .smi_sel   (smi_sel),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .smi_o     (smi_o)
);

// File: tb/irq_hotplug_agg_bench.sv
module irq_hotplug_agg_bench;

    localparam int NP = 2;
    localparam int VW = 4 * NP;

    localparam logic [1:0] K_WR = 2'd0;
    localparam logic [1:0] K_EV = 2'd1;
    localparam logic [1:0] K_RD = 2'd2;

    // {kind[33:32], addr[31:24], data[23:16], exp_rd[15:8], exp_out[7:6] (smi,irq), req[5:0]}
    localparam int NV = 23;
    localparam logic [33:0] VEC [NV] = '{
        {K_RD, 8'h10, 8'h00, 8'h00, 2'b00, 6'd1},   // R1 status zero
        {K_EV, 8'h00, 8'h01, 8'h00, 2'b00, 6'd2},   // R2 p0 device, not enabled
        {K_RD, 8'h10, 8'h00, 8'h01, 2'b00, 6'd2},   // R2
        {K_WR, 8'h11, 8'h01, 8'h00, 2'b01, 6'd7},   // R7 enable -> normal line
        {K_RD, 8'h11, 8'h00, 8'h01, 2'b01, 6'd5},   // R5
        {K_WR, 8'h12, 8'hFF, 8'h00, 2'b10, 6'd6},   // R6 route to smi
        {K_RD, 8'h12, 8'h00, 8'h01, 2'b10, 6'd6},   // R6 upper bits read zero
        {K_WR, 8'h12, 8'h00, 8'h00, 2'b01, 6'd7},   // R7 back to normal
        {K_WR, 8'h10, 8'h00, 8'h00, 2'b01, 6'd3},   // R3 zero write keeps bit
        {K_WR, 8'h10, 8'h01, 8'h00, 2'b00, 6'd3},   // R3 clear
        {K_RD, 8'h10, 8'h00, 8'h00, 2'b00, 6'd3},   // R3
        {K_EV, 8'h00, 8'h80, 8'h00, 2'b00, 6'd2},   // R2 p1 detach
        {K_RD, 8'h10, 8'h00, 8'h80, 2'b00, 6'd2},   // R2 bit 7
        {K_WR, 8'h11, 8'hD1, 8'h00, 2'b01, 6'd7},   // R7
        {K_EV, 8'h00, 8'h20, 8'h00, 2'b01, 6'd2},   // R2 p1 power mgmt
        {K_RD, 8'h10, 8'h00, 8'hA0, 2'b01, 6'd2},   // R2
        {K_WR, 8'h10, 8'h80, 8'h00, 2'b00, 6'd7},   // R7 only masked bit left
        {K_RD, 8'h10, 8'h00, 8'h20, 2'b00, 6'd3},   // R3
        {K_WR, 8'h13, 8'hFF, 8'h00, 2'b00, 6'd8},   // R8 unmapped write
        {K_RD, 8'h13, 8'h00, 8'h00, 2'b00, 6'd8},   // R8 unmapped read
        {K_RD, 8'h11, 8'h00, 8'hD1, 2'b00, 6'd8},   // R8 enable untouched
        {K_EV, 8'h00, 8'h44, 8'h00, 2'b01, 6'd2},   // R2 both ports attach
        {K_RD, 8'h10, 8'h00, 8'h64, 2'b01, 6'd2}    // R2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] evt_dev = '0, evt_pm = '0, evt_add = '0, evt_rem = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [VW-1:0] wr_data = '0;
    logic [VW-1:0] rd_data;
    logic          irq, smi;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_hotplug_agg u_irq_hotplug_agg (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_dev_i (evt_dev),
        .evt_pm_i  (evt_pm),
        .evt_add_i (evt_add),
        .evt_rem_i (evt_rem),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .smi_o     (smi)
    );

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_events(input logic [7:0] v);
        for (int p = 0; p < NP; p++) begin
            evt_dev[p] = v[4*p];
            evt_pm[p]  = v[4*p+1];
            evt_add[p] = v[4*p+2];
            evt_rem[p] = v[4*p+3];
        end
    endtask

    // drive one cycle, then idle one cycle so the router settles
    task automatic do_op(input logic [1:0] kind, input logic [7:0] a,
                         input logic [7:0] d, input logic [7:0] ev);
        @(negedge clk);
        addr    = a;
        wr_data = d;
        wr_en   = (kind == K_WR);
        rd_en   = (kind == K_RD);
        set_events(ev);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        set_events(8'h00);
        @(negedge clk);
    endtask

    task automatic read_chk(input int req, input logic [7:0] a, input logic [7:0] exp);
        do_op(K_RD, a, 8'h00, 8'h00);
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] en_v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check(1, {6'd0, smi, irq}, 8'h00);
        check(1, rd_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k;
            k = VEC[i][33:32];
            do_op(k, VEC[i][31:24], VEC[i][23:16], (k == K_EV) ? VEC[i][23:16] : 8'h00);
            if (k == K_RD) check(int'(VEC[i][5:0]), rd_data, VEC[i][15:8]);
            check(7, {6'd0, smi, irq}, {6'd0, VEC[i][7:6]});   // R7 outputs
        end

        // R9 read data holds while idle
        repeat (3) @(negedge clk);
        check(9, rd_data, 8'h64);

        // R4 set and clear on bit 0 in the same cycle: set wins
        @(negedge clk);
        addr = 8'h10; wr_data = 8'h01; wr_en = 1'b1; evt_dev = 2'b01;
        @(negedge clk);
        wr_en = 1'b0; evt_dev = '0;
        read_chk(4, 8'h10, 8'h65);

        // R10 mask port 0 by read-modify-write, port 1 enables kept
        read_chk(10, 8'h11, 8'hD1);
        en_v = rd_data & 8'hF0;
        do_op(K_WR, 8'h11, en_v, 8'h00);
        read_chk(5, 8'h11, 8'hD0);
        check(7, {6'd0, smi, irq}, 8'h01);      // R7 p1 attach still pending
        do_op(K_WR, 8'h10, 8'hF0, 8'h00);       // clear port 1
        check(7, {6'd0, smi, irq}, 8'h00);      // R7
        // R10 unmask port 0: clear status nibble, then set dev/add/rem
        do_op(K_WR, 8'h10, 8'h0F, 8'h00);
        read_chk(10, 8'h10, 8'h00);
        read_chk(10, 8'h11, 8'hD0);
        en_v = rd_data | 8'h0D;
        do_op(K_WR, 8'h11, en_v, 8'h00);
        do_op(K_EV, 8'h00, 8'h00, 8'h02);        // p0 power mgmt
        check(10, {6'd0, smi, irq}, 8'h00);
        do_op(K_EV, 8'h00, 8'h00, 8'h01);        // p0 device
        check(10, {6'd0, smi, irq}, 8'h01);

        // R6 route pending interrupt to the management line
        do_op(K_WR, 8'h12, 8'h01, 8'h00);
        check(6, {6'd0, smi, irq}, 8'h02);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, {6'd0, smi, irq}, 8'h00);
        rst_n = 1'b1;
        read_chk(1, 8'h10, 8'h00);
        read_chk(1, 8'h11, 8'h00);
        read_chk(1, 8'h12, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule